// File: doc/BRIEF.md
# Field-Aware Capture Event Scheduler

This block raises DMA request strobes for one video capture channel as captured samples arrive in a FIFO. Each cycle the FIFO reports how many new samples it accepted. The block adds them to an accumulator. When the accumulated amount reaches the active threshold, the block issues one event set and keeps the remainder for the next one.

Two thresholds are programmable. The block counts the event sets issued since the last field start. In the field-aware capture modes it moves from the first threshold to the second once that count reaches a per-field limit. Field 1 and field 2 each have their own limit, chosen by the field identifier. The active threshold is also presented on `reload_o`, where a downstream outgoing-data counter can load it.

In the two raw capture modes the per-field limits are ignored. Only the luma strobe is generated, and it always uses the first threshold. The registers sit behind a small word-wide write port with a combinational read port.

Top module: `field_evt_sched`

## Requirements
- R1: After reset both field limits read 0, both thresholds read 8, no strobe is high and `reload_o` is 8.
- R2: Address 0 holds the field-1 limit in bits 11..0 and the field-2 limit in bits 27..16. Address 1 holds threshold 1 in bits 11..0 and threshold 2 in bits 27..16. Bits 31..28 and 15..12 of both words read zero and ignore writes, addresses 2 and 3 read zero, reads are combinational and writes take effect at the next clock edge.
- R3: Each cycle `fill_inc_i` is added to the accumulator. When the sum reaches the active threshold, the strobes pulse on the following cycle and the accumulator keeps the sum minus that threshold.
- R4: In modes 0 and 1 (field-aware), an event set pulses `y_evt_o`, `cb_evt_o` and `cr_evt_o` together for one cycle.
- R5: The event-set counter clears when `field_start_i` is high, and an event in that same cycle is not counted. Otherwise it counts every issued event set and saturates at 4095.
- R6: In modes 0 and 1, threshold 2 is active once the counter is at least the limit of the field selected by `field_id_i` (0 = field 1, 1 = field 2). Otherwise threshold 1 is active, so a limit of 0 selects threshold 2 from the first event of the field.
- R7: `reload_o` always equals the currently active threshold.
- R8: In modes 2 and 3 (raw), only `y_evt_o` pulses, threshold 1 is always active and both field limits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| mode_i | input | 2 | Capture mode: 0/1 field-aware, 2/3 raw |
| field_start_i | input | 1 | Start of a new field |
| field_id_i | input | 1 | Current field: 0 = field 1, 1 = field 2 |
| fill_inc_i | input | 4 | Samples accepted by the FIFO this cycle |
| y_evt_o | output | 1 | Luma event strobe |
| cb_evt_o | output | 1 | Cb event strobe |
| cr_evt_o | output | 1 | Cr event strobe |
| reload_o | output | 12 | Active threshold for the outgoing data counter |

## Verification
`reload_o` and `reg_rdata_o` are combinational from the present state and inputs, so the bench checks them in the same cycle the inputs are driven. The strobes are registered and appear one edge after the cycle whose sum reaches the threshold. The bench drives each step at a falling edge and checks `reload_o` shortly after. It then advances its arithmetic model of the accumulator and counter across the rising edge and compares the strobes at the next falling edge. Register writes change the limits and thresholds only from that edge on, and the model applies them at the same point.

// File: rtl/evt_sched_pkg.sv
package evt_sched_pkg;
  typedef enum logic [1:0] {
    MODE_BT656 = 2'd0,
    MODE_YC    = 2'd1,
    MODE_RAW   = 2'd2,
    MODE_TSI   = 2'd3
  } cap_mode_e;

  localparam int REG_W     = 32;
  localparam int REG_AW    = 2;
  localparam int HI_LSB    = 16;
  localparam int N_CHAN    = 3;
  localparam logic [REG_AW-1:0] ADDR_LIMITS = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_THRESH = 2'd1;

  function automatic logic is_field_mode(cap_mode_e m);
    return (m == MODE_BT656) || (m == MODE_YC);
  endfunction
endpackage

// File: rtl/evt_sched_regs.sv
module evt_sched_regs
  import evt_sched_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int THR_W   = 12,
  parameter int THR_RST = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [CNT_W-1:0]  lim_f1_o,
  output logic [CNT_W-1:0]  lim_f2_o,
  output logic [THR_W-1:0]  thr1_o,
  output logic [THR_W-1:0]  thr2_o
);
  localparam logic [THR_W-1:0] THR_INIT = THR_W'(THR_RST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_f1_o <= '0;
      lim_f2_o <= '0;
      thr1_o   <= THR_INIT;
      thr2_o   <= THR_INIT;
    end else if (we_i) begin
      if (addr_i == ADDR_LIMITS) begin
        lim_f1_o <= wdata_i[CNT_W-1:0];
        lim_f2_o <= wdata_i[HI_LSB+CNT_W-1:HI_LSB];
      end else if (addr_i == ADDR_THRESH) begin
        thr1_o <= wdata_i[THR_W-1:0];
        thr2_o <= wdata_i[HI_LSB+THR_W-1:HI_LSB];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_LIMITS) begin
      rdata_o[CNT_W-1:0]               = lim_f1_o;
      rdata_o[HI_LSB+CNT_W-1:HI_LSB]   = lim_f2_o;
    end else if (addr_i == ADDR_THRESH) begin
      rdata_o[THR_W-1:0]               = thr1_o;
      rdata_o[HI_LSB+THR_W-1:HI_LSB]   = thr2_o;
    end
  end

  a_r2_limit_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_LIMITS) |=>
      (lim_f1_o == $past(wdata_i[CNT_W-1:0]) &&
       lim_f2_o == $past(wdata_i[HI_LSB+CNT_W-1:HI_LSB])));

  a_r2_hold_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(thr1_o) && $stable(thr2_o) && $stable(lim_f1_o)));
endmodule

// File: rtl/evt_thr_select.sv
module evt_thr_select #(
  parameter int CNT_W = 12,
  parameter int THR_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             field_start_i,
  input  logic             field_id_i,
  input  logic             field_mode_i,
  input  logic             fire_i,
  input  logic [CNT_W-1:0] lim_f1_i,
  input  logic [CNT_W-1:0] lim_f2_i,
  input  logic [THR_W-1:0] thr1_i,
  input  logic [THR_W-1:0] thr2_i,
  output logic [THR_W-1:0] thr_act_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] set_cnt_q;
  logic [CNT_W-1:0] lim_sel;
  logic             use_thr2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               set_cnt_q <= '0;
    else if (field_start_i)                    set_cnt_q <= '0;
    else if (fire_i && set_cnt_q != CNT_MAX)   set_cnt_q <= set_cnt_q + 1'b1;
  end

  assign lim_sel   = field_id_i ? lim_f2_i : lim_f1_i;
  assign use_thr2  = field_mode_i && (set_cnt_q >= lim_sel);
  assign thr_act_o = use_thr2 ? thr2_i : thr1_i;

  a_r5_clear_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_start_i |=> (set_cnt_q == '0));

  a_r5_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!field_start_i && !fire_i) |=> $stable(set_cnt_q));

  a_r5_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!field_start_i && set_cnt_q == CNT_MAX) |=> (set_cnt_q == CNT_MAX));
endmodule

// File: rtl/evt_accum.sv
module evt_accum
  import evt_sched_pkg::*;
#(
  parameter int INC_W = 4,
  parameter int THR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [INC_W-1:0]  inc_i,
  input  logic [THR_W-1:0]  thr_i,
  input  logic              field_mode_i,
  output logic              fire_o,
  output logic [N_CHAN-1:0] evt_o
);
  localparam int ACC_W = THR_W + INC_W + 1;

  logic [ACC_W-1:0]  acc_q;
  logic [ACC_W-1:0]  sum;
  logic [N_CHAN-1:0] chan_en;

  assign sum    = acc_q + ACC_W'(inc_i);
  assign fire_o = (sum >= ACC_W'(thr_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (fire_o) acc_q <= sum - ACC_W'(thr_i);
    else             acc_q <= sum;
  end

  // channel 0 is luma, always enabled; chroma only in field-aware modes
  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    assign chan_en[c] = (c == 0) ? 1'b1 : field_mode_i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) evt_o[c] <= 1'b0;
      else         evt_o[c] <= fire_o && chan_en[c];
    end
  end

  a_r3_fire_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> evt_o[0]);

  a_r3_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_o |=> (evt_o == '0));

  a_r4_set_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o[1] || evt_o[2]) |-> (evt_o[0] && evt_o[1] && evt_o[2]));

  a_r8_luma_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !field_mode_i |=> (evt_o[2:1] == 2'b00));
endmodule

// File: rtl/field_evt_sched.sv
module field_evt_sched
  import evt_sched_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int THR_W   = 12,
  parameter int INC_W   = 4,
  parameter int THR_RST = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [1:0]        mode_i,
  input  logic              field_start_i,
  input  logic              field_id_i,
  input  logic [INC_W-1:0]  fill_inc_i,
  output logic              y_evt_o,
  output logic              cb_evt_o,
  output logic              cr_evt_o,
  output logic [THR_W-1:0]  reload_o
);
  logic [CNT_W-1:0]  lim_f1, lim_f2;
  logic [THR_W-1:0]  thr1, thr2, thr_act;
  logic              field_mode, fire;
  logic [N_CHAN-1:0] evt;

  assign field_mode = is_field_mode(cap_mode_e'(mode_i));

  evt_sched_regs #(.CNT_W(CNT_W), .THR_W(THR_W), .THR_RST(THR_RST)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .lim_f1_o (lim_f1),
    .lim_f2_o (lim_f2),
    .thr1_o   (thr1),
    .thr2_o   (thr2)
  );

  evt_thr_select #(.CNT_W(CNT_W), .THR_W(THR_W)) u_sel (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .field_start_i (field_start_i),
    .field_id_i    (field_id_i),
    .field_mode_i  (field_mode),
    .fire_i        (fire),
    .lim_f1_i      (lim_f1),
    .lim_f2_i      (lim_f2),
    .thr1_i        (thr1),
    .thr2_i        (thr2),
    .thr_act_o     (thr_act)
  );

  evt_accum #(.INC_W(INC_W), .THR_W(THR_W)) u_acc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .inc_i        (fill_inc_i),
    .thr_i        (thr_act),
    .field_mode_i (field_mode),
    .fire_o       (fire),
    .evt_o        (evt)
  );

  assign y_evt_o  = evt[0];
  assign cb_evt_o = evt[1];
  assign cr_evt_o = evt[2];
  assign reload_o = thr_act;

  a_r7_reload_choice: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_o == thr1) || (reload_o == thr2));

  a_r8_raw_thr1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !field_mode |-> (reload_o == thr1));
endmodule

// File: tb/field_evt_sched_tb.sv
module field_evt_sched_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [1:0]  mode_i = '0;
  logic        field_start_i = 1'b0;
  logic        field_id_i = 1'b0;
  logic [3:0]  fill_inc_i = '0;
  logic        y_evt_o, cb_evt_o, cr_evt_o;
  logic [11:0] reload_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model state
  int m_acc = 0, m_cnt = 0;
  int m_l1 = 0, m_l2 = 0, m_t1 = 8, m_t2 = 8;

  field_evt_sched dut_i (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int act_thr();
    int lim = field_id_i ? m_l2 : m_l1;
    if (mode_i < 2 && m_cnt >= lim) return m_t2;
    return m_t1;
  endfunction

  // one clock cycle; inputs driven at a falling edge
  task automatic step(int inc, bit fs, bit we = 0, int addr = 0, logic [31:0] wd = 0);
    int thr, sum;
    bit fire;
    fill_inc_i = 4'(inc); field_start_i = fs;
    reg_we_i = we; reg_addr_i = 2'(addr); reg_wdata_i = wd;
    #1;
    thr = act_thr();
    chk(mode_i < 2 ? "R6/R7 reload" : "R8/R7 reload", int'(reload_o), thr);
    sum = m_acc + inc;
    fire = (sum >= thr);
    m_acc = fire ? sum - thr : sum;
    if (fs) m_cnt = 0;
    else if (fire && m_cnt < 4095) m_cnt++;
    if (we && addr == 0) begin m_l1 = int'(wd[11:0]); m_l2 = int'(wd[27:16]); end
    if (we && addr == 1) begin m_t1 = int'(wd[11:0]); m_t2 = int'(wd[27:16]); end
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R3 y strobe", int'(y_evt_o), int'(fire));
    chk(mode_i < 2 ? "R4 cb strobe" : "R8 cb strobe", int'(cb_evt_o), int'(fire && mode_i < 2));
    chk(mode_i < 2 ? "R4 cr strobe" : "R8 cr strobe", int'(cr_evt_o), int'(fire && mode_i < 2));
  endtask

  task automatic rd(int addr, logic [31:0] exp, string req);
    reg_we_i = 0; reg_addr_i = 2'(addr);
    #1;
    chk(req, int'(reg_rdata_o), int'(exp));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    rd(0, 32'h0000_0000, "R1 limits reset");
    rd(1, 32'h0008_0008, "R1 thresholds reset");
    chk("R1 reload reset", int'(reload_o), 8);
    chk("R1 strobes idle", int'({y_evt_o, cb_evt_o, cr_evt_o}), 0);

    // R2 register map, reserved bits
    step(0, 0, 1, 0, 32'hFFFF_FFFF);
    rd(0, 32'h0FFF_0FFF, "R2 limits reserved zero");
    step(0, 0, 1, 1, 32'hF005_F003);
    rd(1, 32'h0005_0003, "R2 thresholds reserved zero");
    step(0, 0, 1, 2, 32'h1234_5678);
    rd(2, 32'h0, "R2 unmapped addr2");
    rd(3, 32'h0, "R2 unmapped addr3");
    rd(1, 32'h0005_0003, "R2 addr2 write ignored");

    // sweep: thresholds 3 then 5, all modes, both fields, limits 0..4
    step(0, 0, 1, 1, {4'h0, 12'd5, 4'h0, 12'd3});
    for (int md = 0; md < 4; md++) begin
      for (int fid = 0; fid < 2; fid++) begin
        for (int lim = 0; lim < 5; lim++) begin
          mode_i = 2'(md); field_id_i = fid[0];
          step(0, 0, 1, 0, fid ? {4'h0, 12'(lim), 16'h0009} : {16'h0009, 4'h0, 12'(lim)});
          step(0, 1);
          for (int k = 0; k < 14; k++) step((k % 4) + 1, 0);
        end
      end
    end

    // R5 field start with event in same cycle is not counted
    mode_i = 0; field_id_i = 0;
    step(0, 0, 1, 0, 32'h0000_0001);
    step(0, 1);
    step(4, 1);
    for (int k = 0; k < 6; k++) step(3, 0);

    // R5 saturation at 4095: thr1=1, thr2=2, limit 4095
    step(0, 0, 1, 1, {4'h0, 12'd2, 4'h0, 12'd1});
    step(0, 0, 1, 0, 32'h0000_0FFF);
    step(0, 1);
    for (int k = 0; k < 4110; k++) step(1, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule